// File: doc/BRIEF.md
# CAN bus-off recovery supervisor

This block watches the bus-off indication of a CAN controller and runs a single, fixed recovery attempt. The first time the controller goes bus-off, the block asks for a full re-initialisation of the controller. Once the controller reports that re-initialisation is done, the block asks for one error frame to be sent. This frame has standard identifier 0x3FF, a data length of one byte and error code 0x12 in byte 0. The block then waits for the controller to report a transmit outcome. If the frame goes out, the block sets a sticky "bus-off happened" flag and returns to normal operation.

Some events lock the block into a permanent halt: a failed transmission, no outcome within a programmable number of cycles, or any further bus-off. While halted, every request output is held low and a halted output is raised. Only the synchronous power-on reset leaves that state. The CAN protocol engine is outside this block. The block only drives the controller's request inputs and reads its status outputs.

Top module: `can_bo_supervisor`

## Requirements
- R1: While reset is high and in the cycle after it is released, reinit_req_o, tx_req_o, bo_seen_o and halted_o are 0, and tx_id_o, tx_dlc_o and tx_data_o are all zero.
- R2: In normal operation with bo_seen_o low, a rising edge of bus_off_i (sampled 0 then 1 on consecutive clock edges) raises reinit_req_o one cycle later. reinit_req_o then stays high until reinit_done_i is sampled high.
- R3: In the cycle after reinit_done_i is sampled high during re-initialisation, reinit_req_o falls and tx_req_o rises. While tx_req_o is high, tx_id_o is 0x3FF, tx_dlc_o is 1 and tx_data_o is 0x12. While tx_req_o is low, these three fields are zero.
- R4: When tx_ok_i is sampled high with tx_req_o high, and tx_fail_i is low and no bus-off edge occurs in that cycle, tx_req_o falls, bo_seen_o rises and halted_o stays low on the next cycle.
- R5: Once set, bo_seen_o stays high until reset, whatever the other inputs do.
- R6: When tx_fail_i is sampled high with tx_req_o high, halted_o rises on the next cycle, even if tx_ok_i is high in the same cycle.
- R7: tx_req_o stays high for at most TIMEOUT_CYCLES cycles. If no outcome arrives in that window, halted_o rises in the next cycle. An outcome sampled on the last cycle of the window is still accepted.
- R8: A rising edge of bus_off_i in normal operation with bo_seen_o high, or while tx_req_o is high, raises halted_o one cycle later.
- R9: Once halted_o is high, it stays high until reset. During that time reinit_req_o and tx_req_o stay low, and no input changes any output.
- R10: Only rising edges of bus_off_i count. A bus-off level that stays high after a successful recovery does not trigger anything. A bus-off edge during re-initialisation is ignored.
- R11: In normal operation, tx_ok_i, tx_fail_i and reinit_done_i have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_off_i | input | 1 | Bus-off level from the CAN controller |
| reinit_req_o | output | 1 | Request full re-initialisation of the controller |
| reinit_done_i | input | 1 | Controller reports re-initialisation complete |
| tx_req_o | output | 1 | Request transmission of the error frame |
| tx_id_o | output | 11 | Standard identifier of the error frame |
| tx_dlc_o | output | 4 | Data length code of the error frame |
| tx_data_o | output | 8 | Byte 0 of the error frame (error code) |
| tx_ok_i | input | 1 | Controller reports frame sent |
| tx_fail_i | input | 1 | Controller reports frame failed |
| bo_seen_o | output | 1 | Sticky flag: a bus-off was recovered from |
| halted_o | output | 1 | Permanent halt until power-on reset |

## Verification
The bench builds the block with TIMEOUT_CYCLES set to 12 instead of the default 4096. This short window lets every recovery round reach the timeout branch within a few cycles. It also lets an outcome be placed exactly on the last accepted cycle and compared with no outcome at all. The error identifier and code keep their default values, so the frame fields are checked against 0x3FF, 1 and 0x12. Random rounds vary the re-initialisation delay, the outcome cycle, the outcome kind and whether bus-off stays high, alongside directed cases for each halt cause.

// File: rtl/can_bo_pkg.sv
package can_bo_pkg;

  localparam int ID_W   = 11;
  localparam int DLC_W  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_REINIT = 2'd1,
    ST_TX     = 2'd2,
    ST_HALT   = 2'd3
  } sup_state_t;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [BYTE_W-1:0] data;
  } err_frame_t;

  localparam int FRAME_W = $bits(err_frame_t);

  function automatic err_frame_t build_frame(input logic [ID_W-1:0] id,
                                             input logic [BYTE_W-1:0] code);
    err_frame_t f;
    f.id   = id;
    f.dlc  = DLC_W'(1);
    f.data = code;
    return f;
  endfunction

endpackage

// File: rtl/bo_rise_det.sv
module bo_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/bo_tx_timer.sv
module bo_tx_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i)     cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/bo_frame_reg.sv
module bo_frame_reg #(
  parameter int WIDTH = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] frame_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] frame_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      frame_o <= '0;
    end else begin
      valid_o <= load_i;
      frame_o <= load_i ? frame_i : '0;
    end
  end
endmodule

// File: rtl/can_bo_supervisor.sv
module can_bo_supervisor
  import can_bo_pkg::*;
#(
  parameter int                TIMEOUT_CYCLES = 4096,
  parameter logic [ID_W-1:0]   ERR_ID         = 11'h3FF,
  parameter logic [BYTE_W-1:0] ERR_CODE       = 8'h12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_off_i,
  output logic              reinit_req_o,
  input  logic              reinit_done_i,
  output logic              tx_req_o,
  output logic [ID_W-1:0]   tx_id_o,
  output logic [DLC_W-1:0]  tx_dlc_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_ok_i,
  input  logic              tx_fail_i,
  output logic              bo_seen_o,
  output logic              halted_o
);
  localparam err_frame_t ERR_FRAME = build_frame(ERR_ID, ERR_CODE);

  sup_state_t st_q, st_n;
  logic       bo_rise;
  logic       tmo_expired;
  logic       seen_q, seen_n;
  logic       reinit_q, halt_q;
  logic [FRAME_W-1:0] frame_bits;
  err_frame_t frame_out;

  bo_rise_det u_rise (
    .clk     (clk),
    .rst     (rst),
    .level_i (bus_off_i),
    .rise_o  (bo_rise)
  );

  bo_tx_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run_i     (st_q == ST_TX),
    .expired_o (tmo_expired)
  );

  always_comb begin
    st_n   = st_q;
    seen_n = seen_q;
    unique case (st_q)
      ST_RUN: begin
        if (bo_rise) st_n = seen_q ? ST_HALT : ST_REINIT;
      end
      ST_REINIT: begin
        if (reinit_done_i) st_n = ST_TX;
      end
      ST_TX: begin
        if (tx_fail_i || bo_rise) begin
          st_n = ST_HALT;
        end else if (tx_ok_i) begin
          st_n   = ST_RUN;
          seen_n = 1'b1;
        end else if (tmo_expired) begin
          st_n = ST_HALT;
        end
      end
      default: st_n = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RUN;
      seen_q   <= 1'b0;
      reinit_q <= 1'b0;
      halt_q   <= 1'b0;
    end else begin
      st_q     <= st_n;
      seen_q   <= seen_n;
      reinit_q <= (st_n == ST_REINIT);
      halt_q   <= (st_n == ST_HALT);
    end
  end

  bo_frame_reg #(.WIDTH(FRAME_W)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .load_i  (st_n == ST_TX),
    .frame_i (ERR_FRAME),
    .valid_o (tx_req_o),
    .frame_o (frame_bits)
  );

  assign frame_out    = err_frame_t'(frame_bits);
  assign tx_id_o      = frame_out.id;
  assign tx_dlc_o     = frame_out.dlc;
  assign tx_data_o    = frame_out.data;
  assign reinit_req_o = reinit_q;
  assign bo_seen_o    = seen_q;
  assign halted_o     = halt_q;
endmodule

// File: rtl/can_bo_supervisor_chk.sv
module can_bo_supervisor_chk
  import can_bo_pkg::*;
#(
  parameter int                TIMEOUT_CYCLES = 4096,
  parameter logic [ID_W-1:0]   ERR_ID         = 11'h3FF,
  parameter logic [BYTE_W-1:0] ERR_CODE       = 8'h12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_off_i,
  input logic              reinit_req_o,
  input logic              reinit_done_i,
  input logic              tx_req_o,
  input logic [ID_W-1:0]   tx_id_o,
  input logic [DLC_W-1:0]  tx_dlc_o,
  input logic [BYTE_W-1:0] tx_data_o,
  input logic              tx_ok_i,
  input logic              tx_fail_i,
  input logic              bo_seen_o,
  input logic              halted_o
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 2);
  logic [TW-1:0] tx_run_q;

  always_ff @(posedge clk) begin
    if (rst || !tx_req_o) tx_run_q <= '0;
    else if (tx_run_q != TW'(TIMEOUT_CYCLES + 1)) tx_run_q <= tx_run_q + 1'b1;
  end

  p_reinit_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(reinit_req_o) |-> ($past(bus_off_i) && !bo_seen_o));

  p_tx_after_done_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_req_o) |-> $past(reinit_req_o && reinit_done_i));

  p_frame_fields_r3: assert property (@(posedge clk) disable iff (rst)
    tx_req_o |-> (tx_id_o == ERR_ID && tx_dlc_o == DLC_W'(1) && tx_data_o == ERR_CODE));

  p_frame_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !tx_req_o |-> (tx_id_o == '0 && tx_dlc_o == '0 && tx_data_o == '0));

  p_seen_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(bo_seen_o) |-> $past(tx_req_o && tx_ok_i && !tx_fail_i));

  p_seen_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    bo_seen_o |=> bo_seen_o);

  p_tx_bounded_r7: assert property (@(posedge clk) disable iff (rst)
    tx_run_q <= TW'(TIMEOUT_CYCLES));

  p_halt_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(halted_o) |-> $past(tx_req_o || bus_off_i));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> halted_o);

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> (!tx_req_o && !reinit_req_o));

  p_req_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(tx_req_o && reinit_req_o));
endmodule

bind can_bo_supervisor can_bo_supervisor_chk #(
  .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
  .ERR_ID         (ERR_ID),
  .ERR_CODE       (ERR_CODE)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_off_i     (bus_off_i),
  .reinit_req_o  (reinit_req_o),
  .reinit_done_i (reinit_done_i),
  .tx_req_o      (tx_req_o),
  .tx_id_o       (tx_id_o),
  .tx_dlc_o      (tx_dlc_o),
  .tx_data_o     (tx_data_o),
  .tx_ok_i       (tx_ok_i),
  .tx_fail_i     (tx_fail_i),
  .bo_seen_o     (bo_seen_o),
  .halted_o      (halted_o)
);

// File: tb/tb_can_bo_supervisor.sv
module tb_can_bo_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 12;
  localparam int K_OK = 0, K_FAIL = 1, K_TMO = 2, K_BO = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_off = 1'b0, done = 1'b0, ok = 1'b0, fail = 1'b0;
  logic reinit_req, tx_req, bo_seen, halted;
  logic [10:0] tx_id;
  logic [3:0]  tx_dlc;
  logic [7:0]  tx_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_bo_supervisor #(.TIMEOUT_CYCLES(TMO)) dut (
    .clk (clk), .rst (rst), .bus_off_i (bus_off),
    .reinit_req_o (reinit_req), .reinit_done_i (done),
    .tx_req_o (tx_req), .tx_id_o (tx_id), .tx_dlc_o (tx_dlc), .tx_data_o (tx_data),
    .tx_ok_i (ok), .tx_fail_i (fail), .bo_seen_o (bo_seen), .halted_o (halted)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_quiet(input string tag, input bit exp_seen, input bit exp_halt);
    chk({tag, " reinit_req"}, 32'(reinit_req), 32'd0);
    chk({tag, " tx_req"}, 32'(tx_req), 32'd0);
    chk({tag, " fields"}, {10'd0, tx_id, tx_dlc, tx_data}, 32'd0);
    chk({tag, " bo_seen"}, 32'(bo_seen), 32'(exp_seen));
    chk({tag, " halted"}, 32'(halted), 32'(exp_halt));
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_off = 1'b0; done = 1'b0; ok = 1'b0; fail = 1'b0;
    step();
    chk_quiet("R1 in reset", 1'b0, 1'b0);
    step();
    rst = 1'b0;
    step();
    chk_quiet("R1 after reset", 1'b0, 1'b0);
  endtask

  function automatic bit exp_halt_of(input int kind);
    return kind != K_OK;
  endfunction

  // One recovery attempt; starts with bus_off low in normal operation.
  task automatic run_recovery(input int kind, input int rdly, input int tdly, input bit keep_bo);
    bus_off = 1'b1;
    step();
    chk("R2 reinit raised", 32'(reinit_req), 32'd1);
    chk("R2 no tx yet", 32'(tx_req), 32'd0);
    for (int i = 0; i < rdly; i++) begin
      step();
      chk("R2 reinit held", 32'(reinit_req), 32'd1);
      chk("R2 tx low while reinit", 32'(tx_req), 32'd0);
    end
    done = 1'b1;
    step();
    done = 1'b0;
    chk("R3 tx raised", 32'(tx_req), 32'd1);
    chk("R3 reinit dropped", 32'(reinit_req), 32'd0);
    chk("R3 id", 32'(tx_id), 32'h3FF);
    chk("R3 dlc", 32'(tx_dlc), 32'd1);
    chk("R3 data", 32'(tx_data), 32'h12);
    if (!keep_bo) bus_off = 1'b0;
    if (kind == K_TMO) begin
      for (int k = 1; k < TMO; k++) begin
        step();
        chk("R7 tx held in window", 32'(tx_req), 32'd1);
        chk("R7 not halted in window", 32'(halted), 32'd0);
      end
      step();
    end else begin
      for (int k = 1; k < tdly; k++) begin
        step();
        chk("R7 tx held", 32'(tx_req), 32'd1);
      end
      if (kind == K_OK)   ok = 1'b1;
      if (kind == K_FAIL) begin ok = 1'b1; fail = 1'b1; end
      if (kind == K_BO)   bus_off = 1'b1;
      step();
      ok = 1'b0; fail = 1'b0;
    end
    case (kind)
      K_OK:    chk_quiet("R4 success", 1'b1, 1'b0);
      K_FAIL:  chk_quiet("R6 failure", 1'b0, 1'b1);
      K_TMO:   chk_quiet("R7 timeout", 1'b0, 1'b1);
      default: chk_quiet("R8 bus-off in tx", 1'b0, 1'b1);
    endcase
  endtask

  task automatic poke_halted(input int n, input bit exp_seen);
    for (int i = 0; i < n; i++) begin
      {bus_off, done, ok, fail} = 4'($urandom);
      step();
      chk_quiet("R9 halted inert", exp_seen, 1'b1);
    end
    {bus_off, done, ok, fail} = 4'd0;
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    // Success, then outside-state inputs, then second bus-off.
    run_recovery(K_OK, 0, 1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      ok = 1'b1; fail = (i % 2) == 1; done = 1'b1;
      step();
      chk_quiet("R11 ignored in run", 1'b1, 1'b0);
    end
    ok = 1'b0; fail = 1'b0; done = 1'b0;
    chk_quiet("R5 flag kept", 1'b1, 1'b0);
    bus_off = 1'b1;
    step();
    chk_quiet("R8 second bus-off", 1'b1, 1'b1);
    poke_halted(20, 1'b1);

    // Failure beats simultaneous ok.
    do_reset();
    run_recovery(K_FAIL, 2, 3, 1'b0);
    poke_halted(8, 1'b0);

    // Outcome on last window cycle accepted, then pure timeout.
    do_reset();
    run_recovery(K_OK, 1, TMO, 1'b0);
    do_reset();
    run_recovery(K_TMO, 1, 0, 1'b0);
    poke_halted(5, 1'b0);

    // Level held high after recovery does not retrigger.
    do_reset();
    run_recovery(K_OK, 1, 2, 1'b1);
    for (int i = 0; i < 6; i++) begin
      step();
      chk_quiet("R10 held level", 1'b1, 1'b0);
    end
    bus_off = 1'b0;

    // Bus-off edge during re-initialisation ignored.
    do_reset();
    bus_off = 1'b1;
    step();
    bus_off = 1'b0;
    step();
    bus_off = 1'b1;
    step();
    chk("R10 reinit still held", 32'(reinit_req), 32'd1);
    chk("R10 no halt in reinit", 32'(halted), 32'd0);
    done = 1'b1;
    step();
    done = 1'b0;
    bus_off = 1'b0;
    chk("R10 tx follows", 32'(tx_req), 32'd1);
    ok = 1'b1;
    step();
    ok = 1'b0;
    chk_quiet("R10 recovery completes", 1'b1, 1'b0);

    // Bus-off edge during transmit request.
    do_reset();
    run_recovery(K_BO, 0, 4, 1'b0);

    // Random rounds.
    for (int r = 0; r < 40; r++) begin
      int kind, rdly, tdly;
      bit keep;
      kind = int'($urandom % 4);
      rdly = int'($urandom % 4);
      tdly = 2 + int'($urandom % (TMO - 1));
      keep = (kind == K_OK) ? 1'($urandom) : 1'b0;
      do_reset();
      run_recovery(kind, rdly, tdly, keep);
      chk("R9 halt expectation", 32'(halted), 32'(exp_halt_of(kind)));
      if (kind == K_OK) begin
        for (int i = 0; i < 5; i++) begin
          {done, ok, fail} = 3'($urandom);
          step();
          chk("R5 flag sticky", 32'(bo_seen), 32'd1);
          chk("R11 no halt", 32'(halted), 32'd0);
        end
        {done, ok, fail} = 3'd0;
        bus_off = 1'b0;
        step();
        bus_off = 1'b1;
        step();
        chk_quiet("R8 later bus-off", 1'b1, 1'b1);
      end else begin
        poke_halted(3, 1'b0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule